// File: doc/BRIEF.md
# Measurement Loop Slot Sequencer

This block paces a repeating ADC measurement loop made of equal time slots. Each slot either starts one conversion for an enabled channel or sits idle. The channels may be cell inputs, auxiliary inputs or internal sensors, and all of them are treated alike. A configuration set drives the loop: a channel-enable mask, a per-channel "real cell" mask, a fast bit that halves the slot length, and a two-bit speed code. The speed code appends idle slots after the conversions to stretch the loop period without adding conversions.

For each active slot the block raises a one-cycle start pulse and presents the channel index. It emits a one-cycle end-of-loop strobe on the final cycle of the loop, which tells downstream protection logic that a complete set of results is ready. A single done line stands in for the converter. The first done of an open slot produces a result strobe with the channel index. The result strobe is raised for every channel. A separate flag tells the protection logic whether the result comes from a real cell or should be left out of cell checks.

Configuration is sampled only at a loop boundary, so one loop always runs under one configuration.

Top module: `meas_loop_seq`

## Requirements
- R1: While rst_n is low, slot_start, slot_idle, loop_end and res_valid are 0. The first slot begins in the cycle after the first rising edge with rst_n high.
- R2: An active slot lasts LEN_FAST cycles when the loop's fast bit is 1 and LEN_NORM cycles when it is 0. slot_start is high for exactly the first cycle of each active slot, so starts occur every slot length.
- R3: Within a loop, the active slots cover the set bits of the enable mask once each, in ascending channel index order. A channel whose enable bit is 0 gets no slot.
- R4: After the last active slot, speed code s (0 to 3) adds s times the number of enabled channels as idle slots. During an idle slot slot_idle is 1 and slot_start is 0.
- R5: loop_end is high for one cycle, on the final cycle of the loop's last slot. The loop period is (1+s) × enabled count × slot length.
- R6: The configuration inputs are sampled only on the final cycle of a loop and on the first edge after reset. A change in the middle of a loop does not alter that loop.
- R7: With an all-zero enable mask, each loop is a single idle slot of the current slot length, closed by loop_end.
- R8: A high adc_done during an active slot whose conversion has not yet completed raises res_valid in the next cycle, with res_ch equal to the slot's channel. Only the first done in a slot counts.
- R9: adc_done during an idle slot produces no res_valid.
- R10: res_prot equals the cell-in-use bit of the result's channel, taken from the configuration of the loop in progress. A result is reported whatever its res_prot value.
- R11: slot_ch stays constant for the whole of an active slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_chan_en | input | NUM_CH | Channel enable mask; bit i gives channel i a slot |
| cfg_cell_use | input | NUM_CH | Channel i is a real cell whose result feeds cell checks |
| cfg_fast | input | 1 | 1 selects the short slot length |
| cfg_speed | input | 2 | Idle multiple appended per loop (0..3) |
| adc_done | input | 1 | Converter completion |
| slot_start | output | 1 | Pulse on the first cycle of an active slot |
| slot_ch | output | CH_W | Channel of the current active slot |
| slot_idle | output | 1 | High for the whole of an idle slot |
| loop_end | output | 1 | Pulse on the last cycle of the loop |
| res_valid | output | 1 | Result strobe, one cycle after an accepted done |
| res_ch | output | CH_W | Channel of the result |
| res_prot | output | 1 | Result should take part in cell protection |

## Verification
The bench checks the exact cycle of every slot start against multiples of the slot length. A design whose slot counter is off by one would drift by a cycle per slot, and a design that drops the fast bit would run at twice the expected period. Sparse masks with the top channel alone, and a fully populated mask, test the forward channel search. A search that wraps or skips would repeat channel 0 or miss channel 15. The empty mask must still produce a strobed one-slot loop instead of stalling or looping at full speed. A configuration changed in the middle of a loop must not reshape that loop. Held or repeated done pulses, including those during idle slots, must not create extra results.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic {
    K_ACT  = 1'b0,
    K_IDLE = 1'b1
  } slot_kind_e;
endpackage

// File: rtl/msq_slot_timer.sv
module msq_slot_timer #(
  parameter int LEN_NORM = 12,
  parameter int LEN_FAST = 6,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fast,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = fast ? CNT_W'(LEN_FAST - 1) : CNT_W'(LEN_NORM - 1);
    last = run && (cnt == lim);
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/msq_first_set.sv
module msq_first_set #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]   mask,
  input  logic [IDX_W:0] from_idx,
  output logic           found,
  output logic [IDX_W-1:0] idx
);
  localparam int FW = IDX_W + 1;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i] && (FW'(i) >= from_idx)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/msq_popcount.sv
module msq_popcount #(
  parameter int N = 16,
  parameter int W = 5
) (
  input  logic [N-1:0] mask,
  output logic [W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + W'(mask[i]);
  end
endmodule

// File: rtl/meas_loop_seq.sv
module meas_loop_seq
  import msq_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int LEN_NORM = 12,
  parameter int LEN_FAST = 6,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cfg_chan_en,
  input  logic [NUM_CH-1:0] cfg_cell_use,
  input  logic              cfg_fast,
  input  logic [1:0]        cfg_speed,
  input  logic              adc_done,
  output logic              slot_start,
  output logic [CH_W-1:0]   slot_ch,
  output logic              slot_idle,
  output logic              loop_end,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_ch,
  output logic              res_prot
);
  localparam int FROM_W  = CH_W + 1;
  localparam int POP_W   = $clog2(NUM_CH + 1);
  localparam int IDLE_W  = $clog2(3 * NUM_CH + 1);
  localparam int LEN_MAX = (LEN_NORM > LEN_FAST) ? LEN_NORM : LEN_FAST;
  localparam int CNT_W   = $clog2(LEN_MAX);

  // state registers
  logic              primed_q, primed_d;
  slot_kind_e        kind_q, kind_d;
  logic [CH_W-1:0]   cur_q, cur_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [NUM_CH-1:0] lat_mask, lat_mask_d;
  logic [NUM_CH-1:0] lat_cell, lat_cell_d;
  logic              lat_fast, lat_fast_d;
  logic              got_q, got_d;
  logic              rv_q;
  logic [CH_W-1:0]   rch_q;
  logic              rprot_q;

  logic [CNT_W-1:0]  cnt;
  logic              slot_last;
  logic              nx_found, f_found;
  logic [CH_W-1:0]   nx_idx, f_idx;
  logic [POP_W-1:0]  pop;
  logic [IDLE_W-1:0] idle_tot;
  logic              loop_last, boundary, accept;

  msq_slot_timer #(.LEN_NORM(LEN_NORM), .LEN_FAST(LEN_FAST), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(primed_q), .fast(lat_fast),
    .cnt(cnt), .last(slot_last)
  );

  msq_first_set #(.N(NUM_CH), .IDX_W(CH_W)) u_next (
    .mask(lat_mask), .from_idx({1'b0, cur_q} + FROM_W'(1)),
    .found(nx_found), .idx(nx_idx)
  );

  msq_first_set #(.N(NUM_CH), .IDX_W(CH_W)) u_first (
    .mask(cfg_chan_en), .from_idx('0),
    .found(f_found), .idx(f_idx)
  );

  msq_popcount #(.N(NUM_CH), .W(POP_W)) u_pop (
    .mask(cfg_chan_en), .count(pop)
  );

  always_comb begin
    idle_tot  = IDLE_W'(cfg_speed) * IDLE_W'(pop);
    loop_last = ((kind_q == K_ACT)  && !nx_found && (idle_q == '0)) ||
                ((kind_q == K_IDLE) && (idle_q == IDLE_W'(1)));
    boundary  = !primed_q || (slot_last && loop_last);
    accept    = adc_done && primed_q && (kind_q == K_ACT) && !got_q;

    primed_d   = primed_q;
    kind_d     = kind_q;
    cur_d      = cur_q;
    idle_d     = idle_q;
    lat_mask_d = lat_mask;
    lat_cell_d = lat_cell;
    lat_fast_d = lat_fast;

    if (boundary) begin
      primed_d   = 1'b1;
      lat_mask_d = cfg_chan_en;
      lat_cell_d = cfg_cell_use;
      lat_fast_d = cfg_fast;
      if (f_found) begin
        kind_d = K_ACT;
        cur_d  = f_idx;
        idle_d = idle_tot;
      end else begin
        kind_d = K_IDLE;
        idle_d = IDLE_W'(1);
      end
    end else if (slot_last) begin
      if (kind_q == K_ACT) begin
        if (nx_found) cur_d = nx_idx;
        else          kind_d = K_IDLE;
      end else begin
        idle_d = idle_q - IDLE_W'(1);
      end
    end

    if (!primed_q || slot_last) got_d = 1'b0;
    else if (accept)            got_d = 1'b1;
    else                        got_d = got_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      kind_q   <= K_ACT;
      cur_q    <= '0;
      idle_q   <= '0;
      lat_mask <= '0;
      lat_cell <= '0;
      lat_fast <= 1'b0;
      got_q    <= 1'b0;
    end else begin
      primed_q <= primed_d;
      kind_q   <= kind_d;
      cur_q    <= cur_d;
      idle_q   <= idle_d;
      lat_mask <= lat_mask_d;
      lat_cell <= lat_cell_d;
      lat_fast <= lat_fast_d;
      got_q    <= got_d;
    end
  end

  // result capture, enabled by an accepted done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rch_q   <= '0;
      rprot_q <= 1'b0;
    end else begin
      rv_q <= accept;
      if (accept) begin
        rch_q   <= cur_q;
        rprot_q <= lat_cell[cur_q];
      end
    end
  end

  assign slot_start = primed_q && (kind_q == K_ACT) && (cnt == '0);
  assign slot_idle  = primed_q && (kind_q == K_IDLE);
  assign slot_ch    = cur_q;
  assign loop_end   = primed_q && slot_last && loop_last;
  assign res_valid  = rv_q;
  assign res_ch     = rch_q;
  assign res_prot   = rprot_q;
endmodule

// File: rtl/msq_chk.sv
module msq_chk #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_start,
  input logic              slot_idle,
  input logic [CH_W-1:0]   slot_ch,
  input logic              loop_end,
  input logic              res_valid,
  input logic              adc_done,
  input logic [NUM_CH-1:0] lat_mask
);
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start);

  a_r3_ch_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> lat_mask[slot_ch]);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idle |-> !slot_start);

  a_r5_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    loop_end |=> !loop_end);

  a_r8_res_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(adc_done));

  a_r9_no_res_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(slot_idle) |-> !res_valid);

  a_r11_ch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_start && !slot_idle && $past(!slot_idle)) |-> $stable(slot_ch));
endmodule

bind meas_loop_seq msq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_idle(slot_idle),
  .slot_ch(slot_ch), .loop_end(loop_end), .res_valid(res_valid),
  .adc_done(adc_done), .lat_mask(lat_mask)
);

// File: tb/meas_loop_seq_bench.sv
`timescale 1ns/1ps
module meas_loop_seq_bench;
  localparam int NCH = 16;
  localparam int LN  = 12;
  localparam int LF  = 6;
  localparam int NV  = 6;

  // {enable, cell, fast, speed}
  localparam logic [34:0] VECS [NV] = '{
    {16'hFFFF, 16'hFFFF, 1'b0, 2'd0},
    {16'h0001, 16'h0000, 1'b1, 2'd3},
    {16'h8421, 16'h0400, 1'b0, 2'd1},
    {16'hA5C3, 16'hA5C3, 1'b1, 2'd2},
    {16'h8000, 16'h0000, 1'b0, 2'd2},
    {16'h0000, 16'h0000, 1'b1, 2'd3}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] cfg_chan_en = '0;
  logic [NCH-1:0] cfg_cell_use = '0;
  logic           cfg_fast = 1'b0;
  logic [1:0]     cfg_speed = '0;
  logic           adc_done = 1'b0;
  logic           slot_start, slot_idle, loop_end, res_valid, res_prot;
  logic [3:0]     slot_ch, res_ch;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  meas_loop_seq u_meas_loop_seq (
    .clk(clk), .rst_n(rst_n), .cfg_chan_en(cfg_chan_en), .cfg_cell_use(cfg_cell_use),
    .cfg_fast(cfg_fast), .cfg_speed(cfg_speed), .adc_done(adc_done),
    .slot_start(slot_start), .slot_ch(slot_ch), .slot_idle(slot_idle),
    .loop_end(loop_end), .res_valid(res_valid), .res_ch(res_ch), .res_prot(res_prot)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic int nth(input logic [15:0] m, input int k);
    int c = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (c == k) return i;
        c++;
      end
    end
    return -1;
  endfunction

  // Called just before the loop's first cycle; returns at its loop_end cycle.
  task automatic measure(input logic [15:0] m, input logic [15:0] c,
                         input bit f, input logic [1:0] s);
    int len    = f ? LF : LN;
    int pop    = popc(m);
    int nslots = (pop == 0) ? 1 : pop * (1 + int'(s));
    int cyc = 0, k = 0, since = 99, idle = 0, cur = -1, ch = 0;
    forever begin
      @(negedge clk);
      if (slot_start) begin
        chk(cyc == k * len, "R2 slot start cycle", cyc, k * len);
        ch = nth(m, k);
        chk(int'(slot_ch) == ch, "R3 channel order", int'(slot_ch), ch);
        cur = ch;
        since = 0;
        k++;
      end else begin
        since++;
      end
      if (slot_idle) begin
        idle++;
        chk(!slot_start, "R4 no start in idle", int'(slot_start), 0);
        chk(!res_valid, "R9 idle done ignored", int'(res_valid), 0);
        adc_done = 1'b1;
      end else begin
        chk(int'(slot_ch) == cur, "R11 channel held", int'(slot_ch), cur);
        if (since == 1) begin
          chk(res_valid, "R8 result strobe", int'(res_valid), 1);
          chk(int'(res_ch) == cur, "R8 result channel", int'(res_ch), cur);
          chk(res_prot == c[cur], "R10 cell flag", int'(res_prot), int'(c[cur]));
        end
        if (since == 2) chk(!res_valid, "R8 second done ignored", int'(res_valid), 0);
        adc_done = (since <= 1);
      end
      if (loop_end) break;
      cyc++;
      if (cyc > 5000) begin
        chk(1'b0, "R5 loop_end missing", cyc, nslots * len);
        break;
      end
    end
    adc_done = 1'b0;
    chk(cyc + 1 == nslots * len, "R5 loop period", cyc + 1, nslots * len);
    chk(k == pop, "R3 active slot count", k, pop);
    chk(idle == (nslots - pop) * len, (pop == 0) ? "R7 empty loop idle" : "R4 idle cycles",
        idle, (nslots - pop) * len);
  endtask

  task automatic apply(input logic [34:0] v);
    {cfg_chan_en, cfg_cell_use, cfg_fast, cfg_speed} = v;
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    chk(!slot_start && !slot_idle && !loop_end && !res_valid, "R1 reset quiet",
        int'({slot_start, slot_idle, loop_end, res_valid}), 0);
    rst_n = 1'b1;
    measure(VECS[0][34:19], VECS[0][18:3], VECS[0][2], VECS[0][1:0]);

    for (int i = 1; i < NV; i++) begin
      apply(VECS[i]);
      measure(VECS[i][34:19], VECS[i][18:3], VECS[i][2], VECS[i][1:0]);
    end

    // R6: change configuration in the middle of a loop
    apply({16'h0F0F, 16'h00FF, 1'b0, 2'd1});
    fork
      measure(16'h0F0F, 16'h00FF, 1'b0, 2'd1);
      begin
        repeat (20) @(negedge clk);
        apply({16'h3000, 16'h1000, 1'b1, 2'd0});
      end
    join
    measure(16'h3000, 16'h1000, 1'b1, 2'd0);

    // R1: reset in the middle of a run, then restart from the first channel
    @(negedge clk);
    rst_n = 1'b0;
    apply({16'h0006, 16'h0002, 1'b1, 2'd1});
    @(negedge clk);
    chk(!slot_start && !slot_idle && !loop_end && !res_valid, "R1 reset mid run",
        int'({slot_start, slot_idle, loop_end, res_valid}), 0);
    rst_n = 1'b1;
    measure(16'h0006, 16'h0002, 1'b1, 2'd1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule